// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block sits between a clocked request interface and an external asynchronous static RAM of 8192 bytes. A user issues a single-byte read or write by raising a request strobe for one clock while the controller is idle. The controller then produces the active-low chip-enable, write-enable and output-enable strobes, presents the address and, for a write, the data. Every window is held for a whole number of clocks computed from nanosecond parameters. When the access completes it pulses `done` and returns to standby.

The defaults describe the slower 70 ns speed grade on a 10 ns clock: read access 7 clocks, write pulse 5 clocks, bus release after a read 3 clocks. The faster grade is obtained by changing the nanosecond parameters only. Writes are write-enable controlled, with output enable held high. The controller never drives the data bus while the memory may still be driving it.

Top module: `asram_ctrl`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `mem_ce_n`, `mem_we_n` and `mem_oe_n` are 1, `mem_dq_oe`, `busy` and `done` are 0, and `rdata` is 0.
- R2: A request is accepted on a rising edge where `req` is 1 and `busy` is 0. `busy` is 1 from the next cycle until the access ends. Whenever `busy` is 0, `mem_ce_n` is 1 and `mem_dq_oe` is 0.
- R3: A read (`wr`=0) drives `mem_ce_n`=0, `mem_oe_n`=0, `mem_we_n`=1 and `mem_addr` equal to the request address for exactly 7 cycles (default), starting the cycle after acceptance. The count is the largest of ceil(70/10), ceil(70/10) and ceil(50/10).
- R4: The read byte is sampled from `mem_dq_in` on the edge that ends the 7-cycle window. It appears on `rdata` in the same cycle that `mem_ce_n` and `mem_oe_n` return to 1, and it holds until the next read completes.
- R5: After a read deasserts the strobes, `busy` stays 1 for 3 cycles (ceil(30/10)) before the next request can be accepted.
- R6: In the first cycle of a write (`wr`=1), `mem_ce_n`=0, `mem_we_n`=1, `mem_oe_n`=1 and `mem_dq_oe`=1, with the address and `mem_dq_out`=`wdata` presented. `mem_we_n` is then 0 for exactly 5 cycles (the largest of ceil(50/10), ceil(30/10) and 7-2). Address and data stay stable throughout.
- R7: After `mem_we_n` rises, one more cycle keeps `mem_ce_n`=0 and the data driven. In the next cycle `mem_ce_n` is 1 and `mem_dq_oe` is 0.
- R8: `mem_addr` never changes while `mem_ce_n` stays 0, and `mem_we_n` is 1 in every cycle in which `mem_addr` changes.
- R9: `mem_dq_oe` is never 1 while `mem_oe_n` is 0, and `mem_oe_n` is 1 whenever `mem_we_n` is 0.
- R10: `done` is a single-cycle pulse per access: in the cycle the read strobes rise, or in the cycle after `mem_we_n` rises for a write.
- R11: `req` is ignored while `busy` is 1. A request held during an access does not alter its address, data or direction.
- R12: A read returns the byte most recently written to the same address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Request strobe, sampled when idle |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | 13 | Request byte address |
| wdata | input | 8 | Write byte |
| rdata | output | 8 | Last byte read |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle completion pulse |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_addr | output | 13 | Memory address lines |
| mem_dq_out | output | 8 | Data driven toward the memory |
| mem_dq_in | input | 8 | Data returned by the memory |
| mem_dq_oe | output | 1 | Drive enable for `mem_dq_out` |

## Verification
Reads are run against a memory model that returns the inverted byte until the access window has fully elapsed. A controller that samples even one clock early therefore shows up as a data mismatch rather than passing by luck. Isolated reads and writes at address 0, the top address and mid-range values are compared with write-after-read and read-after-write pairs. These pairs tell a correct turnaround wait apart from bus contention, which the model flags whenever the drive enable overlaps its own driving or release window. A request held high during an access, and a request held high across many accesses, separate correct request filtering from late or repeated acceptance. A pseudo-random mix of operations then exercises the full sequence of accept, strobe, capture and release.

// File: rtl/asram_pkg.sv
package asram_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD,
        ST_RD_TA,
        ST_WR_SU,
        ST_WR_PULSE,
        ST_WR_HOLD
    } ctrl_state_e;

    typedef struct packed {
        logic ce_n;
        logic we_n;
        logic oe_n;
    } strobe_t;

    localparam strobe_t STRB_IDLE = '{ce_n: 1'b1, we_n: 1'b1, oe_n: 1'b1};

    function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned clk_ns);
        return (ns + clk_ns - 1) / clk_ns;
    endfunction

    function automatic int unsigned umax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    function automatic int unsigned at_least_one(input int unsigned a);
        return (a == 0) ? 1 : a;
    endfunction

endpackage

// File: rtl/asram_timer.sv
module asram_timer #(
    parameter int unsigned TW = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          expired
);
    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/asram_seq.sv
module asram_seq
    import asram_pkg::*;
#(
    parameter int unsigned RD_CYC = 7,
    parameter int unsigned WP_CYC = 5,
    parameter int unsigned TA_CYC = 3,
    parameter int unsigned TW     = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req,
    input  logic          wr,
    input  logic          tmr_expired,
    output logic          tmr_load,
    output logic [TW-1:0] tmr_val,
    output logic          accept,
    output logic          capture,
    output logic          busy,
    output logic          done,
    output logic          drive,
    output strobe_t       strb
);
    ctrl_state_e state_q;

    always_comb begin
        accept   = (state_q == ST_IDLE) && req;
        capture  = (state_q == ST_RD) && tmr_expired;
        busy     = (state_q != ST_IDLE);
        tmr_load = 1'b0;
        tmr_val  = '0;
        case (state_q)
            ST_IDLE: if (req && !wr) begin
                tmr_load = 1'b1;
                tmr_val  = TW'(RD_CYC - 1);
            end
            ST_RD: if (tmr_expired) begin
                tmr_load = 1'b1;
                tmr_val  = TW'(TA_CYC - 1);
            end
            ST_WR_SU: begin
                tmr_load = 1'b1;
                tmr_val  = TW'(WP_CYC - 1);
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            strb    <= STRB_IDLE;
            done    <= 1'b0;
            drive   <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state_q)
                ST_IDLE: if (req) begin
                    strb.ce_n <= 1'b0;
                    if (wr) begin
                        drive   <= 1'b1;
                        state_q <= ST_WR_SU;
                    end else begin
                        strb.oe_n <= 1'b0;
                        state_q   <= ST_RD;
                    end
                end
                ST_RD: if (tmr_expired) begin
                    strb    <= STRB_IDLE;
                    done    <= 1'b1;
                    state_q <= ST_RD_TA;
                end
                ST_RD_TA: if (tmr_expired) state_q <= ST_IDLE;
                ST_WR_SU: begin
                    strb.we_n <= 1'b0;
                    state_q   <= ST_WR_PULSE;
                end
                ST_WR_PULSE: if (tmr_expired) begin
                    strb.we_n <= 1'b1;
                    done      <= 1'b1;
                    state_q   <= ST_WR_HOLD;
                end
                ST_WR_HOLD: begin
                    strb.ce_n <= 1'b1;
                    drive     <= 1'b0;
                    state_q   <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Width of the write pulse, counted for checking only
    logic [TW:0] we_low_q;
    always_ff @(posedge clk) begin
        if (rst || strb.we_n) we_low_q <= '0;
        else                  we_low_q <= we_low_q + 1'b1;
    end

    AST_WE_WIDTH: assert property (@(posedge clk) disable iff (rst)
        $rose(strb.we_n) |-> (we_low_q == (TW+1)'(WP_CYC)));          // R6
    AST_WE_NEEDS_CE: assert property (@(posedge clk) disable iff (rst)
        !strb.we_n |-> !strb.ce_n);                                   // R6
    AST_WE_AFTER_SETUP: assert property (@(posedge clk) disable iff (rst)
        $fell(strb.we_n) |-> ($past(!strb.ce_n) && drive));           // R6
    AST_OE_HIGH_IN_WRITE: assert property (@(posedge clk) disable iff (rst)
        !strb.we_n |-> strb.oe_n);                                    // R9
    AST_NO_DRIVE_ON_READ: assert property (@(posedge clk) disable iff (rst)
        drive |-> strb.oe_n);                                         // R9
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);                                              // R10
    AST_IDLE_DESELECT: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (strb.ce_n && !drive));                             // R2
endmodule

// File: rtl/asram_dpath.sv
module asram_dpath #(
    parameter int unsigned AW = 13,
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          accept,
    input  logic          capture,
    input  logic [AW-1:0] addr_in,
    input  logic [DW-1:0] wdata_in,
    input  logic [DW-1:0] mem_din,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_dout,
    output logic [DW-1:0] rdata
);
    always_ff @(posedge clk) begin
        if (rst) begin
            mem_addr <= '0;
            mem_dout <= '0;
            rdata    <= '0;
        end else begin
            if (accept) begin
                mem_addr <= addr_in;
                mem_dout <= wdata_in;
            end
            if (capture)
                rdata <= mem_din;
        end
    end
endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
    import asram_pkg::*;
#(
    parameter int unsigned CLK_NS    = 10,
    parameter int unsigned ACC_NS    = 70,
    parameter int unsigned OE_ACC_NS = 50,
    parameter int unsigned CYC_NS    = 70,
    parameter int unsigned WP_NS     = 50,
    parameter int unsigned DSU_NS    = 30,
    parameter int unsigned OHZ_NS    = 30,
    parameter int unsigned AW        = 13,
    parameter int unsigned DW        = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req,
    input  logic          wr,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic          busy,
    output logic          done,
    output logic          mem_ce_n,
    output logic          mem_we_n,
    output logic          mem_oe_n,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_dq_out,
    input  logic [DW-1:0] mem_dq_in,
    output logic          mem_dq_oe
);
    localparam int unsigned CYC_C  = ns_to_cyc(CYC_NS, CLK_NS);
    localparam int unsigned RD_CYC = at_least_one(umax(umax(ns_to_cyc(ACC_NS, CLK_NS),
                                         ns_to_cyc(OE_ACC_NS, CLK_NS)), CYC_C));
    localparam int unsigned WP_CYC = at_least_one(umax(umax(ns_to_cyc(WP_NS, CLK_NS),
                                         ns_to_cyc(DSU_NS, CLK_NS)),
                                         (CYC_C > 2) ? CYC_C - 2 : 1));
    localparam int unsigned TA_CYC = at_least_one(ns_to_cyc(OHZ_NS, CLK_NS));
    localparam int unsigned MAXC   = umax(umax(RD_CYC, WP_CYC), TA_CYC);
    localparam int unsigned TW     = at_least_one($clog2(MAXC));

    logic          tmr_load, tmr_expired, accept, capture, drive;
    logic [TW-1:0] tmr_val;
    strobe_t       strb;

    asram_timer #(.TW(TW)) u_timer (
        .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val), .expired(tmr_expired)
    );

    asram_seq #(.RD_CYC(RD_CYC), .WP_CYC(WP_CYC), .TA_CYC(TA_CYC), .TW(TW)) u_seq (
        .clk(clk), .rst(rst), .req(req), .wr(wr), .tmr_expired(tmr_expired),
        .tmr_load(tmr_load), .tmr_val(tmr_val), .accept(accept), .capture(capture),
        .busy(busy), .done(done), .drive(drive), .strb(strb)
    );

    asram_dpath #(.AW(AW), .DW(DW)) u_dpath (
        .clk(clk), .rst(rst), .accept(accept), .capture(capture),
        .addr_in(addr), .wdata_in(wdata), .mem_din(mem_dq_in),
        .mem_addr(mem_addr), .mem_dout(mem_dq_out), .rdata(rdata)
    );

    assign mem_ce_n  = strb.ce_n;
    assign mem_we_n  = strb.we_n;
    assign mem_oe_n  = strb.oe_n;
    assign mem_dq_oe = drive;

    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));       // R8
    AST_WE_ON_ADDR_MOVE: assert property (@(posedge clk) disable iff (rst)
        !$stable(mem_addr) |-> mem_we_n);                             // R8
    AST_DATA_HOLD: assert property (@(posedge clk) disable iff (rst)
        !mem_we_n |-> ($stable(mem_dq_out) && mem_dq_oe));            // R6
endmodule

// File: tb/asram_ctrl_test.sv
module asram_ctrl_test;
    localparam int RD_C = 7;
    localparam int WP_C = 5;
    localparam int TA_C = 3;
    localparam int RD_END = RD_C + TA_C;
    localparam int WR_END = WP_C + 2;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req = 1'b0;
    logic       wr = 1'b0;
    logic [12:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic        busy, done, mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe;
    logic [12:0] mem_addr;
    logic [7:0]  mem_dq_out, mem_dq_in;

    always #5 clk = ~clk;

    asram_ctrl uut (
        .clk(clk), .rst(rst), .req(req), .wr(wr), .addr(addr), .wdata(wdata),
        .rdata(rdata), .busy(busy), .done(done), .mem_ce_n(mem_ce_n),
        .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_addr(mem_addr),
        .mem_dq_out(mem_dq_out), .mem_dq_in(mem_dq_in), .mem_dq_oe(mem_dq_oe)
    );

    int checks = 0;
    int errors = 0;

    // ---------- reference model (posedge) ----------
    logic [7:0]  ref_mem [0:8191];
    bit          m_active;
    bit          m_wr;
    int          m_phase;
    logic [12:0] m_addr;
    logic [7:0]  m_wdata;
    logic [7:0]  m_rdata;
    int          cyc = 0;

    always @(posedge clk) begin
        cyc = cyc + 1;
        if (rst) begin
            m_active = 0;
            m_rdata  = 8'h00;
            for (int i = 0; i < 8192; i++) ref_mem[i] = 8'(i * 7) ^ 8'h3c;
        end else if (m_active) begin
            m_phase = m_phase + 1;
            if (!m_wr && m_phase == RD_C) m_rdata = ref_mem[m_addr];
            if (m_wr && m_phase == WP_C + 1) ref_mem[m_addr] = m_wdata;
            if (m_phase == (m_wr ? WR_END : RD_END)) m_active = 0;
        end else if (req) begin
            m_active = 1;
            m_phase  = 0;
            m_wr     = wr;
            m_addr   = addr;
            m_wdata  = wdata;
        end
    end

    // ---------- memory model and checker (negedge) ----------
    logic [7:0]  sram [0:8191];
    int          age = 0;
    logic [12:0] age_addr = '0;
    int          hz = 0;
    logic        prev_we = 1'b1;
    bit          sram_init = 0;
    logic        mdrv;
    int          probe_id = 0;
    int          last_probe = 0;
    string       probe_tag;
    logic [7:0]  probe_exp;

    assign mdrv = !mem_ce_n && !mem_oe_n && mem_we_n;
    assign mem_dq_in = (mdrv && age >= RD_C) ? sram[mem_addr] :
                       (mdrv ? ~sram[mem_addr] : 8'h00);

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        logic e_ce, e_we, e_oe, e_drv, e_done, e_busy;
        string t;
        if (!sram_init) begin
            for (int i = 0; i < 8192; i++) sram[i] = 8'(i * 7) ^ 8'h3c;
            sram_init = 1;
        end
        // contention: controller drive during memory drive or release
        if (!rst) begin
            checks++;
            if (mem_dq_oe && (mdrv || hz > 0)) begin
                errors++;
                $display("FAIL R9 bus contention: actual oe=%0b hz=%0d expected no drive", mem_dq_oe, hz);
            end
        end
        // memory model state
        if (!mem_oe_n && !mem_ce_n) hz = TA_C; else if (hz > 0) hz = hz - 1;
        if (mdrv) begin
            age = (age == 0 || mem_addr != age_addr) ? 1 : age + 1;
            age_addr = mem_addr;
        end else age = 0;
        if (!prev_we && mem_we_n && !mem_ce_n && mem_dq_oe) sram[mem_addr] = mem_dq_out;
        prev_we = mem_we_n;

        if (rst) begin
            if (cyc > 0) begin
                chk("R1", "ce_n", mem_ce_n, 1); chk("R1", "we_n", mem_we_n, 1);
                chk("R1", "oe_n", mem_oe_n, 1); chk("R1", "dq_oe", mem_dq_oe, 0);
                chk("R1", "busy", busy, 0);     chk("R1", "done", done, 0);
                chk("R1", "rdata", rdata, 0);
            end
        end else begin
            e_ce = 1; e_we = 1; e_oe = 1; e_drv = 0; e_done = 0; e_busy = m_active;
            t = "R2";
            if (m_active && !m_wr) begin
                t = (m_phase < RD_C) ? "R3" : "R5";
                if (m_phase < RD_C) begin e_ce = 0; e_oe = 0; end
                if (m_phase == RD_C) e_done = 1;
            end else if (m_active && m_wr) begin
                t = (m_phase <= WP_C) ? "R6" : "R7";
                if (m_phase <= WP_C + 1) begin e_ce = 0; e_drv = 1; end
                if (m_phase >= 1 && m_phase <= WP_C) e_we = 0;
                if (m_phase == WP_C + 1) e_done = 1;
            end
            chk(t, "ce_n", mem_ce_n, e_ce);
            chk(t, "we_n", mem_we_n, e_we);
            chk(t, "oe_n", mem_oe_n, e_oe);
            chk(t, "dq_oe", mem_dq_oe, e_drv);
            chk(m_active ? t : "R2", "busy", busy, e_busy);
            chk("R10", "done", done, e_done);
            chk("R4", "rdata", rdata, m_rdata);
            if (!e_ce) chk("R8", "mem_addr", mem_addr, m_addr);
            if (e_drv) chk("R6", "dq_out", mem_dq_out, m_wdata);
            if (probe_id != last_probe) begin
                chk(probe_tag, "probe rdata", rdata, probe_exp);
                last_probe = probe_id;
            end
        end
    end

    // ---------- stimulus ----------
    task automatic issue(input bit w, input logic [12:0] a, input logic [7:0] d);
        @(negedge clk);
        while (busy) @(negedge clk);
        req = 1; wr = w; addr = a; wdata = d;
        @(negedge clk);
        req = 0;
        while (busy) @(negedge clk);
    endtask

    task automatic probe(input string tag, input logic [7:0] exp);
        probe_tag = tag;
        probe_exp = exp;
        probe_id  = probe_id + 1;
        @(negedge clk);
    endtask

    task automatic summary;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 0;
        repeat (3) @(negedge clk);
        issue(0, 13'h0000, 8'h00);
        issue(0, 13'h1FFF, 8'h00);
        issue(1, 13'h0123, 8'h5A);
        issue(0, 13'h0123, 8'h00);
        probe("R12", 8'h5A);
        issue(1, 13'h1FFF, 8'hFF);
        issue(1, 13'h0000, 8'h00);
        issue(0, 13'h1FFF, 8'h00);
        probe("R12", 8'hFF);
        issue(0, 13'h0000, 8'h00);
        probe("R12", 8'h00);
        // request pressed while busy must not disturb the access (R11)
        @(negedge clk);
        req = 1; wr = 1; addr = 13'h0AAA; wdata = 8'hC3;
        @(negedge clk);
        wr = 0; addr = 13'h0555; wdata = 8'h99;
        repeat (4) @(negedge clk);
        req = 0;
        while (busy) @(negedge clk);
        issue(0, 13'h0AAA, 8'h00);
        probe("R11", 8'hC3);
        issue(0, 13'h0555, 8'h00);
        probe("R11", 8'(13'h0555 * 7) ^ 8'h3c);
        // request held high across several accesses
        @(negedge clk);
        req = 1; wr = 1; addr = 13'h0055; wdata = 8'h11;
        repeat (30) @(negedge clk);
        req = 0;
        while (busy) @(negedge clk);
        issue(0, 13'h0055, 8'h00);
        probe("R12", 8'h11);
        // mixed traffic
        for (int i = 0; i < 40; i++)
            issue((i % 3) != 1, 13'((i * 1237 + 91) % 8192), 8'((i * 53 + 7) % 256));
        for (int i = 0; i < 40; i++)
            issue(0, 13'((i * 1237 + 91) % 8192), 8'h00);
        repeat (5) @(negedge clk);
        summary();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks + 1, errors + 1);
        $finish;
    end
endmodule